// File: doc/BRIEF.md
# Row-Buffered EEPROM Page Programming Controller

This block sits between a processor's data bus and an EEPROM array and turns a burst of byte writes into a single row commit. Software first sets the enable bit and arms page mode by setting the page-arm bit. Arming clears eight volatile byte latches and a per-byte touched mask. The first data write after arming captures the row address. Later writes to that row fill the latches. Writes or reads aimed elsewhere while page mode is armed are flagged as access errors.

Setting the start bit, which is only accepted when enable and page-arm already read 1, hands the latched row, the eight latch bytes and the touched mask to the array in one write strobe. The controller then stays busy for a fixed number of cycles that stands in for the high-voltage programming time. At the end of that time it clears both page-arm and start itself and pulses done. Software may also drop page-arm without programming, which throws the latched data away.

Top module: `eeprom_row_prog`

## Requirements
- R1: After reset the control readback `ctl_rdata` is 0, and `busy`, `done`, `acc_err` and `arr_we` are all 0.
- R2: A control write that takes page-arm (`ctl_wdata[1]`) from 0 to 1 clears all eight latches and the touched mask, so `arr_data` and `arr_mask` read 0 in the next cycle.
- R3: With page-arm set, the first data write captures its row (`mem_addr[ADDR_W-1:3]`) on `arr_row`. A later write to another row raises `acc_err` for one cycle in the next cycle and changes neither the latches nor the mask. Writes to the captured row store `mem_wdata` in lane `mem_addr[2:0]` and set that mask bit.
- R4: A data read while page-arm is set raises `acc_err` in the next cycle. A read while page-arm is clear does not.
- R5: A control write with `ctl_wdata[2]` set starts programming only if enable (bit 0) and page-arm (bit 1) are already 1 before that write. Otherwise the start bit stays 0, `busy` stays 0, and the other bits of the write apply as usual.
- R6: The start bit is set-only. While `busy` is 1, control writes are ignored, so the start, page-arm and enable bits cannot be changed.
- R7: In the cycle after an accepted start write, `arr_we` is 1 for exactly one cycle. In that cycle `arr_row` holds the captured row, `arr_mask` holds the touched lanes and `arr_data` byte i holds latch i.
- R8: `busy` is 1 for exactly PROG_CYCLES cycles, starting in the `arr_we` cycle. Data writes during that time leave the latches unchanged and raise no error.
- R9: In the first cycle after busy ends, `done` is 1 for one cycle, the page-arm and start bits read 0, enable keeps its value, and `arr_mask` is 0.
- R10: A control write that clears page-arm without starting programming discards the latches and mask and releases the captured row, with no `arr_we` and no `busy`.
- R11: Data writes while page-arm is clear are ignored: latches and mask do not change and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data: bit0 enable, bit1 page-arm, bit2 start |
| ctl_rdata | output | 3 | Control register readback, same layout |
| mem_wr | input | 1 | EEPROM data write strobe |
| mem_rd | input | 1 | EEPROM data read strobe |
| mem_addr | input | ADDR_W | Byte address; upper bits select the row, low 3 bits the lane |
| mem_wdata | input | 8 | Byte written |
| arr_we | output | 1 | One-cycle row commit strobe to the array |
| arr_row | output | ADDR_W-3 | Captured row address |
| arr_mask | output | 8 | Touched lanes, one bit per latch |
| arr_data | output | 64 | Latch contents, lane i in bits 8i+7:8i |
| busy | output | 1 | Programming in progress |
| done | output | 1 | One-cycle pulse when programming ends |
| acc_err | output | 1 | One-cycle access-error pulse |

## Verification
Every result passes through a single register stage. Control readback, latch contents, mask and `acc_err` therefore change one clock after the access that causes them. `arr_we` and `busy` rise one clock after the accepted start write, and `done` appears in the first cycle in which `busy` has dropped back to 0. The bench changes inputs on the falling edge, advances one falling edge per access and reads outputs there, half a period after the rising edge that updated them. It counts busy cycles directly until `busy` falls, then compares that count with PROG_CYCLES.

// File: rtl/eeprom_row_prog.sv
module eeprom_row_prog #(
  parameter int ADDR_W      = 6,
  parameter int PROG_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [2:0]          ctl_wdata,
  output logic [2:0]          ctl_rdata,
  input  logic                mem_wr,
  input  logic                mem_rd,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic [7:0]          mem_wdata,
  output logic                arr_we,
  output logic [ADDR_W-4:0]   arr_row,
  output logic [7:0]          arr_mask,
  output logic [63:0]         arr_data,
  output logic                busy,
  output logic                done,
  output logic                acc_err
);
  localparam int LANES = 8;
  localparam int COL_W = 3;
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

  logic             en, pe, ps, locked;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt;
  logic [LANES-1:0][7:0] lat;
  logic [LANES-1:0] mask;
  logic             we_q, done_q, err_q;

  wire [ROW_W-1:0] a_row = mem_addr[ADDR_W-1:COL_W];
  wire [COL_W-1:0] a_col = mem_addr[COL_W-1:0];
  wire row_hit  = !locked || (a_row == row_q);
  wire wr_open  = mem_wr && pe && !busy;
  wire lat_wr   = wr_open && row_hit;
  wire wr_miss  = wr_open && !row_hit;
  wire rd_bad   = mem_rd && pe;
  wire ctl_ok   = ctl_wr && !busy;
  wire ps_go    = ctl_ok && ctl_wdata[2] && en && pe;
  wire ctl_plain = ctl_ok && !ps_go;
  wire pe_arm   = ctl_plain && ctl_wdata[1] && !pe;
  wire pe_drop  = ctl_plain && !ctl_wdata[1] && pe;
  wire fin      = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; pe <= 1'b0; ps <= 1'b0; busy <= 1'b0;
      locked <= 1'b0; row_q <= '0; cnt <= '0;
      lat <= '0; mask <= '0;
      we_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      we_q   <= ps_go;
      done_q <= fin;
      err_q  <= wr_miss || rd_bad;
      if (ctl_plain) en <= ctl_wdata[0];
      if (ps_go) begin
        ps <= 1'b1; busy <= 1'b1; cnt <= CNT_LAST;
      end else if (busy && !fin) begin
        cnt <= cnt - 1'b1;
      end
      if (fin) begin
        busy <= 1'b0; ps <= 1'b0; pe <= 1'b0;
        locked <= 1'b0; mask <= '0;
      end
      if (lat_wr) begin
        lat[a_col]  <= mem_wdata;
        mask[a_col] <= 1'b1;
        if (!locked) begin
          locked <= 1'b1;
          row_q  <= a_row;
        end
      end
      if (pe_arm || pe_drop) begin
        pe <= pe_arm;
        lat <= '0; mask <= '0; locked <= 1'b0;
      end
    end
  end

  assign ctl_rdata = {ps, pe, en};
  assign arr_we    = we_q;
  assign arr_row   = row_q;
  assign arr_mask  = mask;
  assign arr_data  = lat;
  assign done      = done_q;
  assign acc_err   = err_q;

  // R8
  busy_holds_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ps && pe));
  // R7
  commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (busy && $past(en && pe && !busy)));
  // R9
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !pe && !ps && $past(busy)));
  // R5
  start_interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps) |-> $past(en && pe));
  // R4
  read_armed_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && pe) |=> acc_err);
  // R11
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pe |-> (mask == '0));
  // R6
  ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !done) |-> $stable(en));
endmodule

// File: tb/eeprom_row_prog_test.sv
module eeprom_row_prog_test;
  localparam int AW = 6;
  localparam int PC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [2:0] ctl_wdata = '0;
  logic [2:0] ctl_rdata;
  logic mem_wr = 1'b0, mem_rd = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0;
  logic arr_we, busy, done, acc_err;
  logic [AW-4:0] arr_row;
  logic [7:0] arr_mask;
  logic [63:0] arr_data;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  eeprom_row_prog #(.ADDR_W(AW), .PROG_CYCLES(PC)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .arr_we(arr_we),
    .arr_row(arr_row), .arr_mask(arr_mask), .arr_data(arr_data),
    .busy(busy), .done(done), .acc_err(acc_err));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic wr_mem(input logic [AW-1:0] a, input logic [7:0] d);
    mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_wr = 1'b0;
  endtask

  task automatic rd_mem(input logic [AW-1:0] a);
    mem_rd = 1'b1; mem_addr = a;
    @(negedge clk);
    mem_rd = 1'b0;
  endtask

  task automatic t_reset;
    chk(ctl_rdata == 3'b000, "R1 ctl", 64'(ctl_rdata), 0);
    chk({busy, done, acc_err, arr_we} == 4'b0, "R1 status", 64'({busy, done, acc_err, arr_we}), 0);
  endtask

  task automatic t_idle_write;
    wr_ctl(3'b001);
    wr_mem(6'h00, 8'h77);
    chk(arr_data == 64'h0, "R11 data", arr_data, 0);
    chk(arr_mask == 8'h00 && !acc_err, "R11 mask/err", 64'({acc_err, arr_mask}), 0);
  endtask

  task automatic t_interlock;
    wr_ctl(3'b000);
    wr_ctl(3'b010);
    wr_ctl(3'b110);
    chk(ctl_rdata == 3'b010 && !busy, "R5 no enable", 64'({busy, ctl_rdata}), 64'h2);
    wr_ctl(3'b001);
    wr_ctl(3'b101);
    chk(ctl_rdata == 3'b001 && !busy, "R5 not armed", 64'({busy, ctl_rdata}), 64'h1);
    wr_ctl(3'b000);
    wr_ctl(3'b111);
    chk(ctl_rdata == 3'b011 && !busy && !arr_we, "R5 same write", 64'({arr_we, busy, ctl_rdata}), 64'h3);
    wr_ctl(3'b000);
  endtask

  task automatic t_row_lock;
    wr_ctl(3'b011);
    wr_mem(6'h18, 8'h5A);
    chk(arr_row == 3'd3 && arr_mask == 8'h01 && !acc_err, "R3 capture", 64'({acc_err, arr_row, arr_mask}), 64'h0301);
    wr_mem(6'h21, 8'hEE);
    chk(acc_err == 1'b1, "R3 miss err", 64'(acc_err), 1);
    chk(arr_mask == 8'h01 && arr_data[15:8] == 8'h00, "R3 miss ignored", 64'({arr_data[15:8], arr_mask}), 64'h01);
    wr_mem(6'h1A, 8'h3C);
    chk(!acc_err && arr_mask == 8'h05 && arr_data[23:16] == 8'h3C, "R3 hit", 64'({acc_err, arr_data[23:16], arr_mask}), 64'h3C05);
    rd_mem(6'h18);
    chk(acc_err == 1'b1, "R4 armed read", 64'(acc_err), 1);
    @(negedge clk);
    chk(acc_err == 1'b0, "R4 pulse one cycle", 64'(acc_err), 0);
  endtask

  task automatic t_drop;
    wr_ctl(3'b001);
    chk(arr_mask == 8'h00 && arr_data == 64'h0 && !busy && !arr_we, "R10 discard",
        64'({busy, arr_we, arr_mask}), 0);
    rd_mem(6'h18);
    chk(acc_err == 1'b0, "R4 idle read", 64'(acc_err), 0);
    wr_ctl(3'b011);
    wr_mem(6'h31, 8'h11);
    chk(!acc_err && arr_row == 3'd6, "R10 row released", 64'({acc_err, arr_row}), 64'h6);
    wr_ctl(3'b001);
  endtask

  task automatic t_commit;
    int n;
    wr_ctl(3'b011);
    wr_mem(6'h12, 8'hA1);
    wr_mem(6'h14, 8'hB2);
    wr_mem(6'h15, 8'hC3);
    wr_ctl(3'b111);
    chk(arr_we == 1'b1 && busy == 1'b1, "R7 strobe", 64'({arr_we, busy}), 64'h3);
    chk(arr_row == 3'd2, "R7 row", 64'(arr_row), 2);
    chk(arr_mask == 8'h34, "R7 mask", 64'(arr_mask), 64'h34);
    chk(arr_data == 64'h0000_C3B2_00A1_0000, "R7 data", arr_data, 64'h0000_C3B2_00A1_0000);
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (n == 2) chk(arr_we == 1'b0, "R7 single pulse", 64'(arr_we), 0);
      if (n == 3) begin
        mem_wr = 1'b1; mem_addr = 6'h10; mem_wdata = 8'hFF;
        ctl_wr = 1'b1; ctl_wdata = 3'b000;
      end
      @(negedge clk);
      mem_wr = 1'b0; ctl_wr = 1'b0;
      if (n == 3) chk(ctl_rdata == 3'b111 && !acc_err, "R6 write ignored in busy", 64'({acc_err, ctl_rdata}), 64'h7);
    end
    chk(n == PC, "R8 busy length", 64'(n), 64'(PC));
    chk(done == 1'b1, "R9 done", 64'(done), 1);
    chk(ctl_rdata == 3'b001, "R9 bits cleared", 64'(ctl_rdata), 1);
    chk(arr_mask == 8'h00 && arr_data[7:0] == 8'h00, "R8 latch untouched", 64'({arr_data[7:0], arr_mask}), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse", 64'(done), 0);
    wr_ctl(3'b011);
    chk(arr_data == 64'h0 && arr_mask == 8'h00, "R2 arm clears", arr_data, 0);
    wr_ctl(3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_idle_write;
    t_interlock;
    t_row_lock;
    t_drop;
    t_commit;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule